// File: doc/BRIEF.md
# Distance-Ordered Way Placement Manager

This block manages line placement for a cache whose ways are banks at growing distance from the controller. Each set lives in one column of banks. Position 0 is the nearest and fastest bank, and position WAYS-1 is the farthest. The block keeps a tag and a valid bit for every position of every set. It looks up each accepted request against that model and reports a hit at position k, or a miss.

On a hit at a position other than 0, the line trades places with its nearer neighbour, so a line moves one bank closer per hit. On a miss, the new line enters the farthest empty position. When the set has no empty position, the line in the farthest bank is evicted to memory, with no copy kept, and the new line takes its place. Replacement is therefore an approximate least-recently-used order by physical distance. The block issues the fill, evict and swap commands with their tags, and it keeps one hit counter per position so that the settling of hot lines can be observed.

A swap spends one cycle reading and exchanging the two tags and one cycle writing them back. Requests are refused while a swap is in flight.

Top module: `bankset_placer`

## Requirements
- R1: After reset, reqReady is 1, rspValid, fillValid, evictValid and swapValid are 0, every hit counter is 0, and every position of every set is empty, so the first access to any set misses.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. From that edge, rspValid is 1 for one cycle, with rspSet equal to the request set. rspHit is 1 exactly when the tag is valid in that set, and rspPos is the hit position on a hit or the fill position on a miss.
- R3: A hit at position 0 moves nothing. reqReady stays 1, and swapValid stays 0 in the two cycles that follow.
- R4: A hit at position k>0 raises swapValid for exactly one cycle, starting at the second rising edge after acceptance. That cycle carries swapSet, swapPos = k, swapUpTag = the hit tag and swapDownTag = the tag that was at k-1. From the third edge on, the set holds the hit line at k-1 and the former k-1 line at k, and the valid bits are exchanged with the tags.
- R5: After accepting a hit at k>0, reqReady is 0 for two cycles. A request offered in those cycles is not accepted: it gives no rspValid and no fill, and it changes no tag.
- R6: A miss in a set with at least one empty position raises fillValid together with rspValid. It installs the tag at the farthest empty position, which is the highest empty index, reports that position in rspPos and keeps evictValid at 0.
- R7: A miss in a full set raises evictValid with evictTag equal to the tag at position WAYS-1, and installs the new tag at WAYS-1. The victim is then absent from the set, so a later access to it misses.
- R8: A line that enters by a fill reaches a nearer position only through hits, one position per hit. A line hit repeatedly ends at position 0 and then stays there.
- R9: Field k of hitCounts, bits k*CNT_W up to k*CNT_W+CNT_W-1, counts accepted hits at position k. It is visible from the edge that accepts the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqSet | input | SET_W | Set index of the request |
| reqTag | input | TAG_W | Tag of the request |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | Lookup result valid (one cycle) |
| rspHit | output | 1 | 1 for a hit, 0 for a miss |
| rspPos | output | POS_W | Hit position, or fill position on a miss |
| rspSet | output | SET_W | Set of the reported access |
| fillValid | output | 1 | Install command for the missed line |
| fillTag | output | TAG_W | Tag installed at rspPos |
| evictValid | output | 1 | Victim write-back command |
| evictTag | output | TAG_W | Tag of the evicted line |
| swapValid | output | 1 | Swap command (one cycle) |
| swapSet | output | SET_W | Set of the swap |
| swapPos | output | POS_W | Farther position k of the swapped pair |
| swapUpTag | output | TAG_W | Tag moving from k to k-1 |
| swapDownTag | output | TAG_W | Tag moving from k-1 to k |
| hitCounts | output | WAYS*CNT_W | Per-position hit counters, packed |

## Verification
The response, fill, evict and counter results are due on the edge that accepts a request. The bench therefore drives on a falling edge and checks them on the next falling edge, one full cycle later. Swap commands are due one edge after that. The bench checks swapValid and its tags on the second falling edge, checks reqReady low on both busy falling edges, and checks recovery on the third. The bench's own tag model is updated only at the points where the design commits its state. Requests offered while the block is busy stay on the bus, and the bench then confirms that no response appears and that later lookups still match the unchanged model.

// File: rtl/bankset_placer_pkg.sv
package bankset_placer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XCHG  = 2'd1,
    ST_WRITE = 2'd2
  } swapState_t;

  typedef struct packed {
    logic accept;
    logic xchg;
    logic write;
  } ctrlStrobe_t;
endpackage

// File: rtl/bankset_placer_ctrl.sv
module bankset_placer_ctrl
  import bankset_placer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        lookupFar,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  swapState_t state, stateNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.accept = reqValid && (state == ST_IDLE);
    strobe.xchg   = (state == ST_XCHG);
    strobe.write  = (state == ST_WRITE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.accept && lookupHit && lookupFar) stateNext = ST_XCHG;
      ST_XCHG:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/bankset_placer_dp.sv
module bankset_placer_dp
  import bankset_placer_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [SET_W-1:0]      reqSet,
  input  logic [TAG_W-1:0]      reqTag,
  output logic                  lookupHit,
  output logic                  lookupFar,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic [POS_W-1:0]      rspPos,
  output logic [SET_W-1:0]      rspSet,
  output logic                  fillValid,
  output logic [TAG_W-1:0]      fillTag,
  output logic                  evictValid,
  output logic [TAG_W-1:0]      evictTag,
  output logic                  swapValid,
  output logic [SET_W-1:0]      swapSet,
  output logic [POS_W-1:0]      swapPos,
  output logic [TAG_W-1:0]      swapUpTag,
  output logic [TAG_W-1:0]      swapDownTag,
  output logic [WAYS*CNT_W-1:0] hitCounts
);
  localparam logic [POS_W-1:0] FAR_POS = POS_W'(WAYS - 1);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [CNT_W-1:0] hitCnt   [WAYS];

  logic [WAYS-1:0]  matchVec;
  logic [POS_W-1:0] hitPos;
  logic [POS_W-1:0] emptyPos;
  logic             anyEmpty;
  logic [POS_W-1:0] fillPos;
  logic             setFull;

  logic [SET_W-1:0] curSet;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] nearPos;
  logic [TAG_W-1:0] xNearTag, xFarTag;
  logic             xNearValid, xFarValid;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : gMatch
      assign matchVec[g] = validMem[reqSet][g] && (tagMem[reqSet][g] == reqTag);
    end
    for (g = 0; g < WAYS; g++) begin : gCntOut
      assign hitCounts[g*CNT_W +: CNT_W] = hitCnt[g];
    end
  endgenerate

  always_comb begin
    hitPos   = '0;
    emptyPos = '0;
    anyEmpty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (matchVec[w]) hitPos = POS_W'(w);
      if (!validMem[reqSet][w]) begin
        anyEmpty = 1'b1;
        emptyPos = POS_W'(w);
      end
    end
    setFull   = !anyEmpty;
    fillPos   = anyEmpty ? emptyPos : FAR_POS;
    lookupHit = |matchVec;
    lookupFar = (hitPos != '0);
  end

  assign nearPos     = curPos - POS_W'(1);
  assign swapValid   = strobe.write;
  assign swapSet     = curSet;
  assign swapPos     = curPos;
  assign swapUpTag   = xFarTag;
  assign swapDownTag = xNearTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) tagMem[s][w] <= '0;
      end
      for (int w = 0; w < WAYS; w++) hitCnt[w] <= '0;
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspPos     <= '0;
      rspSet     <= '0;
      fillValid  <= 1'b0;
      fillTag    <= '0;
      evictValid <= 1'b0;
      evictTag   <= '0;
      curSet     <= '0;
      curPos     <= '0;
      xNearTag   <= '0;
      xFarTag    <= '0;
      xNearValid <= 1'b0;
      xFarValid  <= 1'b0;
    end else begin
      rspValid   <= strobe.accept;
      fillValid  <= strobe.accept && !lookupHit;
      evictValid <= strobe.accept && !lookupHit && setFull;
      if (strobe.accept) begin
        rspHit   <= lookupHit;
        rspPos   <= lookupHit ? hitPos : fillPos;
        rspSet   <= reqSet;
        fillTag  <= reqTag;
        evictTag <= tagMem[reqSet][WAYS-1];
        curSet   <= reqSet;
        curPos   <= hitPos;
        if (lookupHit) begin
          hitCnt[hitPos] <= hitCnt[hitPos] + CNT_W'(1);
        end else begin
          tagMem[reqSet][fillPos]   <= reqTag;
          validMem[reqSet][fillPos] <= 1'b1;
        end
      end
      if (strobe.xchg) begin
        xNearTag   <= tagMem[curSet][nearPos];
        xFarTag    <= tagMem[curSet][curPos];
        xNearValid <= validMem[curSet][nearPos];
        xFarValid  <= validMem[curSet][curPos];
      end
      if (strobe.write) begin
        tagMem[curSet][nearPos]   <= xFarTag;
        tagMem[curSet][curPos]    <= xNearTag;
        validMem[curSet][nearPos] <= xFarValid;
        validMem[curSet][curPos]  <= xNearValid;
      end
    end
  end
endmodule

// File: rtl/bankset_placer.sv
module bankset_placer
  import bankset_placer_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [SET_W-1:0]      reqSet,
  input  logic [TAG_W-1:0]      reqTag,
  output logic                  reqReady,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic [POS_W-1:0]      rspPos,
  output logic [SET_W-1:0]      rspSet,
  output logic                  fillValid,
  output logic [TAG_W-1:0]      fillTag,
  output logic                  evictValid,
  output logic [TAG_W-1:0]      evictTag,
  output logic                  swapValid,
  output logic [SET_W-1:0]      swapSet,
  output logic [POS_W-1:0]      swapPos,
  output logic [TAG_W-1:0]      swapUpTag,
  output logic [TAG_W-1:0]      swapDownTag,
  output logic [WAYS*CNT_W-1:0] hitCounts
);
  ctrlStrobe_t strobe;
  logic        lookupHit;
  logic        lookupFar;

  bankset_placer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lookupHit (lookupHit),
    .lookupFar (lookupFar),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  bankset_placer_dp #(
    .SETS (SETS), .WAYS (WAYS), .TAG_W (TAG_W), .CNT_W (CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqSet      (reqSet),
    .reqTag      (reqTag),
    .lookupHit   (lookupHit),
    .lookupFar   (lookupFar),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspPos      (rspPos),
    .rspSet      (rspSet),
    .fillValid   (fillValid),
    .fillTag     (fillTag),
    .evictValid  (evictValid),
    .evictTag    (evictTag),
    .swapValid   (swapValid),
    .swapSet     (swapSet),
    .swapPos     (swapPos),
    .swapUpTag   (swapUpTag),
    .swapDownTag (swapDownTag),
    .hitCounts   (hitCounts)
  );
endmodule

// File: rtl/bankset_placer_chk.sv
module bankset_placer_chk #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [SET_W-1:0] reqSet,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspHit,
  input logic [POS_W-1:0] rspPos,
  input logic [SET_W-1:0] rspSet,
  input logic             fillValid,
  input logic             evictValid,
  input logic             swapValid,
  input logic [POS_W-1:0] swapPos
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspValid && rspSet == $past(reqSet))); // R2
  AST_NO_RSP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid); // R5
  AST_NEAR_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspPos == '0) |-> (reqReady && !swapValid)); // R3
  AST_FAR_HIT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspPos != '0) |-> !reqReady); // R5
  AST_SWAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspPos != '0) |=> (swapValid && swapPos == $past(rspPos))); // R4
  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    swapValid |=> (!swapValid && reqReady)); // R4
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (rspValid && !rspHit)); // R6
  AST_EVICT_AT_FAR: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> (fillValid && rspPos == POS_W'(WAYS - 1))); // R7
endmodule

bind bankset_placer bankset_placer_chk #(
  .SETS (SETS), .WAYS (WAYS), .TAG_W (TAG_W), .CNT_W (CNT_W)
) chk_i (.*);

// File: tb/bankset_placer_tb.sv
module bankset_placer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;
  localparam int SET_W = 2;
  localparam int POS_W = 2;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0;
  logic [SET_W-1:0]      reqSet = '0;
  logic [TAG_W-1:0]      reqTag = '0;
  logic                  reqReady, rspValid, rspHit, fillValid, evictValid, swapValid;
  logic [POS_W-1:0]      rspPos, swapPos;
  logic [SET_W-1:0]      rspSet, swapSet;
  logic [TAG_W-1:0]      fillTag, evictTag, swapUpTag, swapDownTag;
  logic [WAYS*CNT_W-1:0] hitCounts;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mTag   [SETS][WAYS];
  bit mValid [SETS][WAYS];
  int mCnt   [WAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankset_placer #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSet(reqSet), .reqTag(reqTag),
    .reqReady(reqReady), .rspValid(rspValid), .rspHit(rspHit), .rspPos(rspPos),
    .rspSet(rspSet), .fillValid(fillValid), .fillTag(fillTag), .evictValid(evictValid),
    .evictTag(evictTag), .swapValid(swapValid), .swapSet(swapSet), .swapPos(swapPos),
    .swapUpTag(swapUpTag), .swapDownTag(swapDownTag), .hitCounts(hitCounts)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int findPos(input int s, input int t);
    int p = -1;
    for (int w = 0; w < WAYS; w++) if (mValid[s][w] && mTag[s][w] == t) p = w;
    return p;
  endfunction

  function automatic int farEmpty(input int s);
    int p = -1;
    for (int w = 0; w < WAYS; w++) if (!mValid[s][w]) p = w;
    return p;
  endfunction

  task automatic checkCounters(input string req);
    for (int w = 0; w < WAYS; w++)
      chk(req, "hit counter", int'(hitCounts[w*CNT_W +: CNT_W]), mCnt[w]);
  endtask

  // Starts and ends on a falling edge.
  task automatic doAccess(input int s, input int t, input bit pokeBusy);
    int ePos = findPos(s, t);
    int eEmpty = farEmpty(s);
    bit eHit = (ePos >= 0);
    int fPos = (eEmpty >= 0) ? eEmpty : WAYS - 1;
    int tmpT;
    bit tmpV;
    reqValid = 1'b1;
    reqSet = SET_W'(s);
    reqTag = TAG_W'(t);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", "rspValid", int'(rspValid), 1);
    chk("R2", "rspHit", int'(rspHit), int'(eHit));
    chk("R2", "rspSet", int'(rspSet), s);
    chk("R2", "rspPos", int'(rspPos), eHit ? ePos : fPos);
    chk("R6", "fillValid", int'(fillValid), int'(!eHit));
    if (!eHit) chk("R6", "fillTag", int'(fillTag), t);
    chk("R7", "evictValid", int'(evictValid), int'(!eHit && eEmpty < 0));
    if (!eHit && eEmpty < 0) chk("R7", "evictTag", int'(evictTag), mTag[s][WAYS-1]);
    if (eHit) mCnt[ePos]++;
    else begin
      mTag[s][fPos] = t;
      mValid[s][fPos] = 1'b1;
    end
    checkCounters("R9");
    if (eHit && ePos > 0) begin
      chk("R5", "reqReady busy 1", int'(reqReady), 0);
      chk("R4", "swapValid early", int'(swapValid), 0);
      if (pokeBusy) begin
        reqValid = 1'b1;
        reqTag = TAG_W'(t ^ 8'hA5);
      end
      @(negedge clk);
      chk("R4", "swapValid", int'(swapValid), 1);
      chk("R4", "swapSet", int'(swapSet), s);
      chk("R4", "swapPos", int'(swapPos), ePos);
      chk("R4", "swapUpTag", int'(swapUpTag), mTag[s][ePos]);
      chk("R4", "swapDownTag", int'(swapDownTag), mTag[s][ePos-1]);
      chk("R5", "reqReady busy 2", int'(reqReady), 0);
      chk("R5", "rspValid busy", int'(rspValid), 0);
      @(negedge clk);
      reqValid = 1'b0;
      chk("R4", "swapValid after", int'(swapValid), 0);
      chk("R5", "rspValid after busy", int'(rspValid), 0);
      chk("R5", "fillValid after busy", int'(fillValid), 0);
      chk("R5", "reqReady back", int'(reqReady), 1);
      tmpT = mTag[s][ePos];   tmpV = mValid[s][ePos];
      mTag[s][ePos] = mTag[s][ePos-1];   mValid[s][ePos] = mValid[s][ePos-1];
      mTag[s][ePos-1] = tmpT; mValid[s][ePos-1] = tmpV;
    end else if (eHit) begin
      chk("R3", "reqReady", int'(reqReady), 1);
      @(negedge clk);
      chk("R3", "swapValid 1", int'(swapValid), 0);
      @(negedge clk);
      chk("R3", "swapValid 2", int'(swapValid), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1D5E));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mTag[s][w] = 0; mValid[s][w] = 1'b0; end
    for (int w = 0; w < WAYS; w++) mCnt[w] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady", int'(reqReady), 1);
    chk("R1", "rspValid", int'(rspValid), 0);
    chk("R1", "fillValid", int'(fillValid), 0);
    chk("R1", "evictValid", int'(evictValid), 0);
    chk("R1", "swapValid", int'(swapValid), 0);
    checkCounters("R1");

    // R1 R6: empty set fills from the farthest position inward.
    doAccess(0, 8'h11, 1'b0);
    chk("R6", "first fill at far", int'(rspPos), WAYS - 1);
    doAccess(0, 8'h22, 1'b0);
    doAccess(0, 8'h33, 1'b0);
    doAccess(0, 8'h44, 1'b0);
    chk("R6", "last fill at near", int'(rspPos), 0);
    // R3: hit nearest.
    doAccess(0, 8'h44, 1'b0);
    // R4 R5: hit far while another request waits.
    doAccess(0, 8'h11, 1'b1);
    doAccess(0, 8'h11, 1'b0);
    chk("R4", "moved one nearer", int'(rspPos), WAYS - 2);
    // R7: full set evicts far line (0x22), victim then misses.
    doAccess(0, 8'h55, 1'b0);
    chk("R7", "evicted tag", int'(evictTag), 8'h22);
    doAccess(0, 8'h22, 1'b0);
    chk("R7", "victim misses", int'(rspHit), 0);
    // R8: hot line climbs one per hit and settles at 0.
    for (int i = 0; i < WAYS + 1; i++) begin
      doAccess(0, 8'h22, 1'b0);
      chk("R8", "climb position", int'(rspPos), (WAYS - 1 - i) < 0 ? 0 : (WAYS - 1 - i));
    end

    // Constrained random mix across sets with a hot subset of tags.
    for (int i = 0; i < 400; i++) begin
      int s = int'($urandom % SETS);
      int t = ($urandom % 3 != 0) ? int'(1 + $urandom % 2) : int'(1 + $urandom % 9);
      doAccess(s, t, bit'($urandom % 2));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule